// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received payload octets for one channel into memory buffers described by a circular table of descriptors. Each table entry is eight bytes: a 32-bit word holding a status halfword and a length halfword, followed by a 32-bit buffer address. The engine reads the current entry through a simple single-cycle-latency descriptor memory port. It uses the entry only if software has marked it as owned by hardware and its buffer address is burst-aligned. It then writes arriving octets to consecutive buffer addresses through a fire-and-forget data write port.

A buffer is closed when its frame ends, when reception is aborted, or when the programmed buffer size has been reached. On close, the engine writes back the stored octet count and the updated status. It then steps to the next entry, or returns to the table base when the entry carries the wrap flag. A frame that fills a buffer continues into the next entry. Closing can also post an interrupt-queue event, feed a coalescing counter that pulses a global interrupt flag, and pulse a strobe that captures signaling data.

The payload side is a valid/ready octet stream with an end-of-frame flag and an abort flag. Software ownership, cell reassembly and data memory arbitration are outside the block.

Top module: `rxbd_ring_engine`

## Requirements
- R1: After reset, `in_ready`, `bd_req`, `dw_valid` and `evt_valid` are 0 and nothing is fetched while `cfg_en` is 0. The first descriptor read after `cfg_en` is set is at `cfg_base`.
- R2: A descriptor word at entry offset 0 holds status in bits 31:16 and length in bits 15:0. The word at offset 4 is the buffer address. Status bits are: owned-by-hardware (called E) = bit 31, wrap = bit 29, interrupt = bit 28, continuous = bit 25, end-of-superframe = bit 22. Octets are written only into a buffer whose E bit was 1.
- R3: On close, the written-back status equals the fetched status, except that E becomes 0 unless the continuous bit is 1, in which case E stays 1.
- R4: After closing an entry with wrap = 1, the next entry fetched is at `cfg_base`. Otherwise it is the entry 8 bytes further on.
- R5: Closing an entry whose interrupt bit is 1 pulses `evt_valid` for one cycle, with `evt_addr` equal to the entry address. With the interrupt bit at 0, no event is posted.
- R6: Each posted event advances a counter. When the count reaches `cfg_irq_thresh` (0 behaves as 1), `gint` pulses once and the count restarts from 0.
- R7: The written-back length is the number of octets stored in the buffer. An end-of-frame beat stores its octet and closes the buffer. An abort beat stores nothing and closes the buffer.
- R8: When a buffer holds `cfg_buf_size` octets (0 behaves as 1), it closes, and the remaining octets of the frame go into the next entry.
- R9: Closing an entry whose end-of-superframe bit is 1 pulses `sig_capture`, but only while `cfg_ces` is 1.
- R10: If a frame starts while the current entry has E = 0 even after a re-read, `err_busy` pulses once and the whole frame is consumed and discarded. The same entry is read again for the next frame.
- R11: If an owned entry has a buffer address that is not a multiple of `BURST_BYTES`, `err_align` pulses once and the frame is discarded as in R10.
- R12: If stepping past an entry without wrap would put the next entry at `SPAN_BYTES` or more beyond `cfg_base`, `err_span` pulses and the next entry is taken from `cfg_base`.
- R13: The n-th octet stored in a buffer (counting from 0) is written to buffer address + n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Channel enable; 0 returns the engine to idle |
| cfg_ces | input | 1 | Circuit-emulation mode; gates signaling capture |
| cfg_base | input | AW | Byte address of the first table entry |
| cfg_buf_size | input | 16 | Buffer capacity in octets |
| cfg_irq_thresh | input | CW | Event count that raises the global interrupt |
| bd_req | output | 1 | Descriptor memory access request |
| bd_we | output | 1 | Descriptor memory write (1) or read (0) |
| bd_addr | output | AW | Descriptor memory byte address |
| bd_wdata | output | 32 | Descriptor write data |
| bd_rdata | input | 32 | Read data, valid the cycle after a read request |
| in_valid | input | 1 | Payload beat valid |
| in_ready | output | 1 | Payload beat accepted |
| in_data | input | 8 | Payload octet |
| in_last | input | 1 | Beat carries the final octet of the frame |
| in_abort | input | 1 | Beat aborts the frame and carries no octet |
| dw_valid | output | 1 | Data memory write strobe |
| dw_addr | output | AW | Data memory byte address |
| dw_data | output | 8 | Data memory octet |
| evt_valid | output | 1 | Receive-buffer event for the interrupt queue |
| evt_addr | output | AW | Address of the closed entry |
| gint | output | 1 | Global interrupt pulse at the coalescing threshold |
| sig_capture | output | 1 | Strobe to capture signaling data |
| err_busy | output | 1 | Frame dropped: entry not owned by hardware |
| err_align | output | 1 | Frame dropped: misaligned buffer address |
| err_span | output | 1 | Table span exceeded; ring restarted at base |

## Verification
The hardest case to reach is a frame that arrives while the engine holds a stale snapshot of a descriptor that software has since changed. The engine must re-read the entry before it decides to drop the frame. The stimulus gets there by closing an entry to software, sending a frame into it (which must be dropped), and only then re-arming it in the bench memory while the engine sits waiting. The next frame must land in that same entry. The same pattern covers a misaligned address that is corrected between frames, and a constrained-random phase then mixes frame lengths, buffer-full splits and aborts against a bench model of the ring.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  // Length halfword width is fixed by the descriptor layout.
  localparam int LEN_W       = 16;
  localparam int ENTRY_BYTES = 8;
  localparam int PTR_OFFSET  = 4;

  // Status halfword bit positions (bit 15 = most significant).
  localparam int ST_OWN  = 15;
  localparam int ST_WRAP = 13;
  localparam int ST_INTR = 12;
  localparam int ST_CONT = 9;
  localparam int ST_EOSF = 6;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_STAT,
    S_RD_PTR,
    S_LD_PTR,
    S_RUN,
    S_DROP,
    S_CLOSE
  } rxbd_state_e;
endpackage

// File: rtl/rxbd_reset_sync.sv
module rxbd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rxbd_ptr_guard.sv
module rxbd_ptr_guard #(
  parameter int AW          = 32,
  parameter int SPAN_BYTES  = 65536,
  parameter int BURST_BYTES = 32
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          wrap_i,
  output logic [AW-1:0] next_o,
  output logic          span_err_o,
  output logic          align_err_o
);
  import rxbd_pkg::*;

  localparam logic [AW-1:0] STEP       = AW'(ENTRY_BYTES);
  localparam logic [AW-1:0] SPAN_LIM   = AW'(SPAN_BYTES);
  localparam logic [AW-1:0] ALIGN_MASK = AW'(BURST_BYTES - 1);

  logic [AW-1:0] next_offs;

  always_comb begin
    next_offs   = cur_i - base_i + STEP;
    span_err_o  = !wrap_i && (next_offs >= SPAN_LIM);
    next_o      = (wrap_i || span_err_o) ? base_i : (cur_i + STEP);
    align_err_o = |(ptr_i & ALIGN_MASK);
  end
endmodule

// File: rtl/rxbd_irq_coalesce.sv
module rxbd_irq_coalesce #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_i,
  input  logic [CW-1:0] thresh_i,
  output logic          gint_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] thr_eff;
  logic          hit;
  logic          gint_d;

  always_comb begin
    thr_eff = (thresh_i == '0) ? CW'(1) : thresh_i;
    hit     = evt_i && (({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, thr_eff});
    cnt_d   = cnt_q;
    if (evt_i) cnt_d = hit ? '0 : (cnt_q + CW'(1));
    gint_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      gint_o <= 1'b0;
    end else begin
      if (evt_i) cnt_q <= cnt_d;
      gint_o <= gint_d;
    end
  end

  // R6: the flag only follows an event, and the count restarts with it
  assert_gint_after_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gint_o |-> $past(evt_i));
  assert_gint_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gint_o |-> (cnt_q == '0));
endmodule

// File: rtl/rxbd_ring_engine.sv
module rxbd_ring_engine #(
  parameter int AW          = 32,
  parameter int CW          = 8,
  parameter int SPAN_BYTES  = 65536,
  parameter int BURST_BYTES = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_ces,
  input  logic [AW-1:0] cfg_base,
  input  logic [15:0]   cfg_buf_size,
  input  logic [CW-1:0] cfg_irq_thresh,
  output logic          bd_req,
  output logic          bd_we,
  output logic [AW-1:0] bd_addr,
  output logic [31:0]   bd_wdata,
  input  logic [31:0]   bd_rdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_abort,
  output logic          dw_valid,
  output logic [AW-1:0] dw_addr,
  output logic [7:0]    dw_data,
  output logic          evt_valid,
  output logic [AW-1:0] evt_addr,
  output logic          gint,
  output logic          sig_capture,
  output logic          err_busy,
  output logic          err_align,
  output logic          err_span
);
  import rxbd_pkg::*;

  localparam logic [AW-1:0] ALIGN_MASK = AW'(BURST_BYTES - 1);

  logic              rst_s_n;
  rxbd_state_e       st_q, st_d;
  logic [AW-1:0]     cur_q, cur_d;
  logic [AW-1:0]     ptr_q;
  logic [15:0]       stat_q;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              recheck_q, recheck_d;
  logic              stat_en, ptr_en;
  logic [AW-1:0]     next_cur;
  logic              span_bad, ptr_bad;
  logic              owned, usable;
  logic [LEN_W-1:0]  buf_lim;
  logic              buf_full;
  logic [15:0]       stat_close;
  logic              closing;

  rxbd_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  rxbd_ptr_guard #(
    .AW          (AW),
    .SPAN_BYTES  (SPAN_BYTES),
    .BURST_BYTES (BURST_BYTES)
  ) u_guard (
    .cur_i       (cur_q),
    .base_i      (cfg_base),
    .ptr_i       (ptr_q),
    .wrap_i      (stat_q[ST_WRAP]),
    .next_o      (next_cur),
    .span_err_o  (span_bad),
    .align_err_o (ptr_bad)
  );

  rxbd_irq_coalesce #(.CW(CW)) u_irq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .evt_i    (evt_valid),
    .thresh_i (cfg_irq_thresh),
    .gint_o   (gint)
  );

  // Snapshot qualifiers and closing status
  always_comb begin
    owned      = stat_q[ST_OWN];
    usable     = owned && !ptr_bad;
    buf_lim    = (cfg_buf_size == '0) ? LEN_W'(1) : cfg_buf_size;
    buf_full   = (({1'b0, cnt_q} + (LEN_W+1)'(1)) >= {1'b0, buf_lim});
    stat_close = stat_q;
    stat_close[ST_OWN] = stat_q[ST_CONT];
    closing    = cfg_en && (st_q == S_CLOSE);
  end

  // Next-state and port logic
  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    cnt_d     = cnt_q;
    recheck_d = recheck_q;
    stat_en   = 1'b0;
    ptr_en    = 1'b0;
    bd_req    = 1'b0;
    bd_we     = 1'b0;
    bd_addr   = cur_q;
    bd_wdata  = '0;
    in_ready  = 1'b0;
    dw_valid  = 1'b0;
    err_busy  = 1'b0;
    err_align = 1'b0;

    case (st_q)
      S_IDLE: begin
        recheck_d = 1'b0;
        if (cfg_en) begin
          cur_d = cfg_base;
          st_d  = S_RD_STAT;
        end
      end
      S_RD_STAT: begin
        bd_req = 1'b1;
        cnt_d  = '0;
        st_d   = S_RD_PTR;
      end
      S_RD_PTR: begin
        bd_req  = 1'b1;
        bd_addr = cur_q + AW'(PTR_OFFSET);
        stat_en = 1'b1;
        st_d    = S_LD_PTR;
      end
      S_LD_PTR: begin
        ptr_en = 1'b1;
        st_d   = S_RUN;
      end
      S_RUN: begin
        in_ready = usable || recheck_q;
        if (in_valid) begin
          if (!usable) begin
            if (!recheck_q) begin
              // snapshot may be stale: read the entry again before judging
              recheck_d = 1'b1;
              st_d      = S_RD_STAT;
            end else begin
              err_busy  = !owned;
              err_align = owned;
              recheck_d = 1'b0;
              st_d      = (in_last || in_abort) ? S_RD_STAT : S_DROP;
            end
          end else if (in_abort) begin
            recheck_d = 1'b0;
            st_d      = S_CLOSE;
          end else begin
            dw_valid = 1'b1;
            cnt_d    = cnt_q + LEN_W'(1);
            if (in_last || buf_full) begin
              recheck_d = 1'b0;
              st_d      = S_CLOSE;
            end
          end
        end
      end
      S_DROP: begin
        in_ready = 1'b1;
        if (in_valid && (in_last || in_abort)) st_d = S_RD_STAT;
      end
      S_CLOSE: begin
        bd_req   = 1'b1;
        bd_we    = 1'b1;
        bd_wdata = {stat_close, cnt_q};
        cur_d    = next_cur;
        st_d     = S_RD_STAT;
      end
      default: st_d = S_IDLE;
    endcase

    if (!cfg_en) begin
      st_d      = S_IDLE;
      bd_req    = 1'b0;
      bd_we     = 1'b0;
      in_ready  = 1'b0;
      dw_valid  = 1'b0;
      err_busy  = 1'b0;
      err_align = 1'b0;
    end
  end

  assign dw_addr     = ptr_q + AW'(cnt_q);
  assign dw_data     = in_data;
  assign evt_valid   = closing && stat_q[ST_INTR];
  assign evt_addr    = cur_q;
  assign sig_capture = closing && stat_q[ST_EOSF] && cfg_ces;
  assign err_span    = closing && span_bad;

  // Registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q      <= S_IDLE;
      cur_q     <= '0;
      ptr_q     <= '0;
      stat_q    <= '0;
      cnt_q     <= '0;
      recheck_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cur_q     <= cur_d;
      cnt_q     <= cnt_d;
      recheck_q <= recheck_d;
      if (stat_en) stat_q <= bd_rdata[31:16];
      if (ptr_en)  ptr_q  <= AW'(bd_rdata);
    end
  end

  // R2: octets land only in a buffer owned by hardware
  assert_owned_write_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    dw_valid |-> stat_q[ST_OWN]);
  // R3: written-back ownership follows the continuous flag
  assert_close_owner_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    bd_we |-> (bd_wdata[16+ST_OWN] == stat_q[ST_CONT]));
  // R4: wrap returns to the base, otherwise step one entry
  assert_wrap_base_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (closing && stat_q[ST_WRAP]) |=> (cur_q == $past(cfg_base)));
  assert_step_entry_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (closing && !stat_q[ST_WRAP] && !err_span) |=> (cur_q == $past(cur_q) + AW'(ENTRY_BYTES)));
  // R5: an event is posted only with a close write-back
  assert_evt_on_close_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    evt_valid |-> (bd_req && bd_we));
  // R7/R8: stored length never exceeds the buffer size
  assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    bd_we |-> (bd_wdata[15:0] <= buf_lim));
  // R9: capture strobe only in circuit-emulation mode, at a close
  assert_sig_gate_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    sig_capture |-> (cfg_ces && bd_we));
  // R10: a busy report consumes the beat without storing it
  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_busy |-> (in_ready && !dw_valid));
  // R11: no octet is written through a misaligned address
  assert_aligned_write_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    dw_valid |-> ((ptr_q & ALIGN_MASK) == '0));
  // R12: a span overrun restarts the ring at the base
  assert_span_restart_R12: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_span |=> (cur_q == $past(cfg_base)));
endmodule

// File: tb/rxbd_ring_engine_test.sv
module rxbd_ring_engine_test;
  localparam int AW = 32;
  localparam logic [15:0] F_E   = 16'h8000;
  localparam logic [15:0] F_W   = 16'h2000;
  localparam logic [15:0] F_I   = 16'h1000;
  localparam logic [15:0] F_CM  = 16'h0200;
  localparam logic [15:0] F_EOS = 16'h0040;
  localparam int BASE_W = 32'h100 >> 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, cfg_en, cfg_ces;
  logic [AW-1:0] cfg_base;
  logic [15:0]   cfg_buf_size;
  logic [7:0]    cfg_irq_thresh;
  logic          bd_req, bd_we;
  logic [AW-1:0] bd_addr;
  logic [31:0]   bd_wdata, bd_rdata;
  logic          in_valid, in_ready, in_last, in_abort;
  logic [7:0]    in_data;
  logic          dw_valid;
  logic [AW-1:0] dw_addr;
  logic [7:0]    dw_data;
  logic          evt_valid, gint, sig_capture, err_busy, err_align, err_span;
  logic [AW-1:0] evt_addr;

  rxbd_ring_engine #(.SPAN_BYTES(32)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_ces(cfg_ces),
    .cfg_base(cfg_base), .cfg_buf_size(cfg_buf_size), .cfg_irq_thresh(cfg_irq_thresh),
    .bd_req(bd_req), .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata), .bd_rdata(bd_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last), .in_abort(in_abort),
    .dw_valid(dw_valid), .dw_addr(dw_addr), .dw_data(dw_data),
    .evt_valid(evt_valid), .evt_addr(evt_addr), .gint(gint), .sig_capture(sig_capture),
    .err_busy(err_busy), .err_align(err_align), .err_span(err_span)
  );

  logic [31:0] bdmem [0:255];
  logic [7:0]  dmem  [0:4095];

  always @(posedge clk) begin
    if (bd_req) begin
      if (bd_we) bdmem[bd_addr[9:2]] <= bd_wdata;
      else       bd_rdata <= bdmem[bd_addr[9:2]];
    end
    if (dw_valid) dmem[dw_addr[11:0]] <= dw_data;
  end

  int checks = 0, fails = 0;
  int evt_n = 0, gint_n = 0, sig_n = 0, busy_n = 0, align_n = 0, span_n = 0;
  logic        got_first = 1'b0;
  logic [31:0] first_addr = '0;
  logic [31:0] last_evt_addr = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (evt_valid) begin evt_n++; last_evt_addr <= evt_addr; end
      if (gint) gint_n++;
      if (sig_capture) sig_n++;
      if (err_busy) busy_n++;
      if (err_align) align_n++;
      if (err_span) span_n++;
      if (bd_req && !got_first) begin got_first <= 1'b1; first_addr <= bd_addr; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bptr(input int idx);
    return 32'h400 + 32'(idx) * 32'h40;
  endfunction

  task automatic arm(input int idx, input logic [15:0] st, input logic [31:0] p);
    bdmem[BASE_W + 2*idx]     = {st, 16'h0000};
    bdmem[BASE_W + 2*idx + 1] = p;
  endtask

  function automatic logic [15:0] bstat(input int idx);
    return bdmem[BASE_W + 2*idx][31:16];
  endfunction

  function automatic logic [15:0] blen(input int idx);
    return bdmem[BASE_W + 2*idx][15:0];
  endfunction

  task automatic beat(input logic [7:0] d, input logic last, input logic abort);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last; in_abort = abort;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_last = 1'b0; in_abort = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic frame(input int n, input logic [7:0] first, input bit abort);
    for (int i = 0; i < n; i++) beat(first + 8'(i), !abort && (i == n-1), 1'b0);
    if (abort) beat(8'h00, 1'b0, 1'b1);
    settle();
  endtask

  // bench model for the random phase
  logic [7:0] exp_d [0:255];
  bit         exp_v [0:255];
  int         exp_len [0:3];
  int         midx, mcnt, m_evt, m_gint, mc;

  task automatic model_close();
    exp_len[midx] = mcnt;
    m_evt++;
    mc++;
    if (mc >= 3) begin m_gint++; mc = 0; end
    midx = (midx == 3) ? 0 : midx + 1;
    mcnt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit ab;
    logic [7:0] b;
    int bad;

    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_en = 1'b0; cfg_ces = 1'b1;
    cfg_base = 32'h100; cfg_buf_size = 16'd8; cfg_irq_thresh = 8'd2;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_abort = 1'b0;
    for (int a = 0; a < 256; a++) bdmem[a] = '0;
    for (int a = 0; a < 4096; a++) dmem[a] = '0;
    for (int k = 0; k < 3; k++) arm(k, F_E | F_I, bptr(k));
    arm(3, F_E | F_I | F_W, bptr(3));

    repeat (4) @(negedge clk);
    chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    chk(bd_req == 1'b0 && dw_valid == 1'b0, "R1", "bd_req/dw_valid in reset", bd_req, 0);
    chk(evt_valid == 1'b0, "R1", "evt_valid in reset", evt_valid, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(got_first == 1'b0, "R1", "fetch while disabled", got_first, 0);
    cfg_en = 1'b1;
    settle();
    chk(first_addr == 32'h100, "R1", "first fetch address", first_addr, 32'h100);

    // R7/R13/R3/R5: short frame into entry 0
    frame(5, 8'h10, 1'b0);
    chk(blen(0) == 16'd5, "R7", "entry0 length", blen(0), 5);
    chk(bstat(0) == F_I, "R3", "entry0 status", bstat(0), F_I);
    chk(dmem[12'h400] == 8'h10 && dmem[12'h404] == 8'h14, "R13", "entry0 data", dmem[12'h404], 8'h14);
    chk(evt_n == 1 && last_evt_addr == 32'h100, "R5", "event on close", evt_n, 1);
    chk(gint_n == 0, "R6", "no global flag below threshold", gint_n, 0);

    // R8: 12 octets split across entries 1 and 2
    frame(12, 8'h20, 1'b0);
    chk(blen(1) == 16'd8, "R8", "entry1 full length", blen(1), 8);
    chk(blen(2) == 16'd4, "R8", "entry2 remainder length", blen(2), 4);
    chk(dmem[12'h447] == 8'h27 && dmem[12'h480] == 8'h28, "R13", "split data", dmem[12'h480], 8'h28);
    chk(evt_n == 3, "R5", "event count", evt_n, 3);
    chk(gint_n == 1, "R6", "global flag at threshold 2", gint_n, 1);

    // R7 abort on entry 3 (wrap)
    frame(3, 8'h30, 1'b1);
    chk(blen(3) == 16'd3, "R7", "aborted length", blen(3), 3);
    chk(bstat(3) == (F_W | F_I), "R3", "entry3 status", bstat(3), F_W | F_I);
    chk(gint_n == 2, "R6", "global flag count", gint_n, 2);

    // R10: wrapped onto entry 0 still owned by software
    frame(4, 8'h40, 1'b0);
    chk(busy_n == 1, "R10", "busy pulses", busy_n, 1);
    chk(dmem[12'h400] == 8'h10, "R10", "dropped frame not stored", dmem[12'h400], 8'h10);
    chk(blen(0) == 16'd5, "R10", "entry0 untouched", blen(0), 5);
    arm(0, F_E | F_CM | F_EOS, bptr(0));
    frame(2, 8'h50, 1'b0);
    chk(blen(0) == 16'd2 && dmem[12'h400] == 8'h50, "R4", "retry lands in wrapped entry0", blen(0), 2);
    chk(bstat(0) == (F_E | F_CM | F_EOS), "R3", "continuous keeps ownership", bstat(0), F_E | F_CM | F_EOS);
    chk(sig_n == 1, "R9", "signaling strobe in ces mode", sig_n, 1);
    chk(busy_n == 1, "R10", "no extra busy on retry", busy_n, 1);

    // R9: strobe suppressed without ces mode
    cfg_ces = 1'b0;
    arm(1, F_E | F_EOS, bptr(1));
    frame(3, 8'h60, 1'b0);
    chk(blen(1) == 16'd3 && bstat(1) == F_EOS, "R9", "entry1 closed", blen(1), 3);
    chk(sig_n == 1, "R9", "no strobe without ces", sig_n, 1);

    // R11: misaligned buffer address, then corrected
    arm(2, F_E, 32'h404);
    frame(4, 8'h70, 1'b0);
    chk(align_n == 1, "R11", "align error pulses", align_n, 1);
    chk(dmem[12'h404] == 8'h14 && dmem[12'h408] == 8'h00, "R11", "misaligned frame not stored", dmem[12'h404], 8'h14);
    arm(2, F_E, bptr(2));
    frame(4, 8'h80, 1'b0);
    chk(blen(2) == 16'd4 && dmem[12'h480] == 8'h80, "R11", "corrected entry2 used", blen(2), 4);

    // R12: entry 3 without wrap overruns a 32-byte span
    arm(3, F_E | F_I, bptr(3));
    frame(2, 8'h90, 1'b0);
    chk(span_n == 1, "R12", "span error pulses", span_n, 1);
    chk(blen(3) == 16'd2, "R12", "entry3 closed", blen(3), 2);
    frame(3, 8'hA0, 1'b0);
    chk(blen(0) == 16'd3 && dmem[12'h400] == 8'hA0, "R12", "restart at base", blen(0), 3);
    chk(evt_n == 5 && gint_n == 2, "R5", "events before random phase", evt_n, 5);

    // Random phase: continuous entries, threshold 3
    cfg_irq_thresh = 8'd3;
    for (int k = 0; k < 3; k++) arm(k, F_E | F_CM | F_I, bptr(k));
    arm(3, F_E | F_CM | F_I | F_W, bptr(3));
    for (int a = 0; a < 256; a++) exp_v[a] = 1'b0;
    for (int k = 0; k < 4; k++) exp_len[k] = 0;
    midx = 1; mcnt = 0; m_evt = evt_n; m_gint = gint_n; mc = 1;
    for (int f = 0; f < 40; f++) begin
      n  = 1 + int'($urandom_range(0, 19));
      ab = ($urandom_range(0, 3) == 0);
      for (int i = 0; i < n; i++) begin
        b = 8'($urandom);
        exp_d[midx*64 + mcnt] = b;
        exp_v[midx*64 + mcnt] = 1'b1;
        mcnt++;
        if (mcnt == 8 || (!ab && i == n-1)) model_close();
        beat(b, !ab && (i == n-1), 1'b0);
      end
      if (ab) begin beat(8'h00, 1'b0, 1'b1); model_close(); end
      settle();
      bad = 0;
      for (int k = 0; k < 4; k++) if (int'(blen(k)) != exp_len[k] || !bstat(k)[15]) bad++;
      chk(bad == 0, "R8", "random lengths and ownership", bad, 0);
      chk(evt_n == m_evt && gint_n == m_gint, "R6", "random event/global counts", gint_n, m_gint);
    end
    bad = 0;
    for (int a = 0; a < 256; a++) if (exp_v[a] && dmem[12'h400 + a] != exp_d[a]) bad++;
    chk(bad == 0, "R13", "random payload placement", bad, 0);
    chk(busy_n == 1 && align_n == 1 && span_n == 1, "R10", "no errors in random phase", busy_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule